// File: doc/BRIEF.md
# I2C Byte-Stepped Bus Master

This block is a single-master I2C controller that moves one byte per software request. Software writes a small control word that holds a go bit, a start request, a stop request, an acknowledge choice and a receive/transmit select, together with the byte to transmit. The block then generates a START if one is needed, shifts eight data bits MSB first and handles the ninth (acknowledge) bit. After that bit it parks the bus with SCL pulled low, or ends the transfer with a STOP when one was queued.

Completion is reported through sticky status flags: transmit done, receive full, stop done and bus error. Software clears them by writing ones into a clear mask. The interrupt output is high while any flag is set. Both bus lines are open-drain: the block only pulls a line low or lets it go. The SCL half-period is set in system clocks by an input, and a value of zero selects a built-in default meant for 100 kHz operation.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both bus lines are released, `busy` is 0, `status` is 4'b0000 and `irq` is 0.
- R2: A control write with `ctrl_tb`=1 while `busy` is 0 raises `busy` and starts exactly one 9-bit byte transfer. `busy` falls when the acknowledge bit's high phase ends. Control writes made while `busy` is 1 are ignored, including their data and their direction.
- R3: After the acknowledge bit, unless a STOP was queued, the block keeps SCL pulled low indefinitely until the next control write with `ctrl_tb`=1.
- R4: A byte requested while the bus is idle is always preceded by a START. A byte requested from the parked state is preceded by a repeated START only when `ctrl_start` is 1, and otherwise continues with no START.
- R5: `ctrl_stop`=1 queues a STOP that appears only after that byte's acknowledge bit. When the STOP completes, the block sets `status[2]` and releases both lines.
- R6: In receive mode (`ctrl_rx`=1) the block drives the ninth bit low (ACK) when `ctrl_nak`=0 and leaves it released (NAK) when `ctrl_nak`=1.
- R7: In transmit mode the byte goes out MSB first, and the block samples the slave's acknowledge. A released (high) acknowledge sets `status[3]` (bus error), and the block then parks as usual.
- R8: `status[0]` (transmit done) and `status[1]` (receive full, with `rx_data` loaded) are set in the same cycle that `busy` falls and never while a byte is in progress.
- R9: Status flags are sticky. A cycle with `stat_we`=1 clears each flag whose `stat_clr` bit is 1, and `irq` is high while any flag is set.
- R10: The SCL period during data bits is 2×`half_period` system clocks. `half_period`=0 selects the default of 625 clocks per half-period.
- R11: SDA changes while SCL is released only to form a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | HP_W | SCL half-period in clocks; 0 selects the default |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_tb | input | 1 | Go: transfer one byte |
| ctrl_start | input | 1 | Request a (repeated) START before the byte |
| ctrl_stop | input | 1 | Queue a STOP after the byte |
| ctrl_nak | input | 1 | Receive mode: NAK the received byte |
| ctrl_rx | input | 1 | 1 = receive byte, 0 = transmit byte |
| tx_data | input | 8 | Byte to transmit, captured with the control write |
| stat_we | input | 1 | Status clear strobe |
| stat_clr | input | 4 | Write-one-to-clear mask for `status` |
| busy | output | 1 | Transfer-byte bit readback |
| rx_data | output | 8 | Last received byte |
| status | output | 4 | {bus error, stop done, receive full, transmit done} |
| irq | output | 1 | Any status flag set |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |

## Verification
On every cycle, assertions check the following: SCL stays low while the block is parked; `busy` falls only at the end of an acknowledge bit; transmit-done and receive-full rise only together with that fall; a clear request empties a flag that is not being set; and SDA holds still under a released SCL except during START and STOP. The directed scenarios are the only way to show the rest. These are the bytes actually seen on the wire, the ACK or NAK the master gives and the reaction to a slave NAK. They also cover repeated-START versus plain continuation, the placement of a queued STOP, control writes ignored during a byte, and the measured SCL period for a programmed and a default divider.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int HP_W = 16,
  parameter int DEFAULT_HALF = 625
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HP_W-1:0] half_period,
  input  logic            ctrl_we,
  input  logic            ctrl_tb,
  input  logic            ctrl_start,
  input  logic            ctrl_stop,
  input  logic            ctrl_nak,
  input  logic            ctrl_rx,
  input  logic [7:0]      tx_data,
  input  logic            stat_we,
  input  logic [3:0]      stat_clr,
  output logic            busy,
  output logic [7:0]      rx_data,
  output logic [3:0]      status,
  output logic            irq,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_low,
  output logic            sda_low
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_RS, ST_SA, ST_SB, ST_BLO, ST_BHI, ST_PA, ST_PB, ST_PC
  } state_t;

  state_t          st;
  logic [HP_W-1:0] cnt;
  logic [3:0]      idx;
  logic [7:0]      shreg;
  logic            tb_q, start_q, stop_q, nak_q, rx_q;
  logic            sda_q, sda_next;
  logic [3:0]      flags, flag_set;

  wire [HP_W-1:0] hp_eff = (half_period == '0) ? HP_W'(DEFAULT_HALF) : half_period;
  wire tick     = (cnt == hp_eff - 1'b1);
  wire ack_done = (st == ST_BHI) && tick && (idx == 4'd8);

  assign flag_set[0] = ack_done && !rx_q;
  assign flag_set[1] = ack_done && rx_q;
  assign flag_set[2] = (st == ST_PC) && tick;
  assign flag_set[3] = ack_done && !rx_q && sda_i;

  assign busy    = tb_q;
  assign status  = flags;
  assign irq     = |flags;
  assign sda_low = sda_q;
  assign scl_low = (st == ST_HOLD) || (st == ST_RS) || (st == ST_BLO) || (st == ST_PA);

  always_comb begin
    sda_next = 1'b0;
    case (st)
      ST_SB, ST_PA, ST_PB: sda_next = 1'b1;
      ST_BLO, ST_BHI:
        if (idx == 4'd8) sda_next = rx_q && !nak_q;
        else             sda_next = !rx_q && !shreg[7];
      default: sda_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      rx_data <= '0;
      tb_q    <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      nak_q   <= 1'b0;
      rx_q    <= 1'b0;
      sda_q   <= 1'b0;
      flags   <= '0;
    end else begin
      sda_q <= sda_next;
      flags <= (flags & ~(stat_we ? stat_clr : 4'b0000)) | flag_set;

      if (st == ST_IDLE || st == ST_HOLD || tick) cnt <= '0;
      else                                        cnt <= cnt + 1'b1;

      if (ctrl_we && !tb_q) begin
        tb_q    <= ctrl_tb;
        start_q <= ctrl_start;
        stop_q  <= ctrl_stop;
        nak_q   <= ctrl_nak;
        rx_q    <= ctrl_rx;
        shreg   <= tx_data;
      end

      case (st)
        ST_IDLE: if (tb_q) begin st <= ST_SA; idx <= '0; end
        ST_HOLD: if (tb_q) begin st <= start_q ? ST_RS : ST_BLO; idx <= '0; end
        ST_RS:   if (tick) st <= ST_SA;
        ST_SA:   if (tick) st <= ST_SB;
        ST_SB:   if (tick) st <= ST_BLO;
        ST_BLO:  if (tick) st <= ST_BHI;
        ST_BHI:
          if (tick) begin
            if (idx != 4'd8) begin
              shreg <= {shreg[6:0], sda_i};
              idx   <= idx + 1'b1;
              st    <= ST_BLO;
            end else begin
              tb_q <= 1'b0;
              if (rx_q) rx_data <= shreg;
              st <= stop_q ? ST_PA : ST_HOLD;
            end
          end
        ST_PA:   if (tick) st <= ST_PB;
        ST_PB:   if (tick) st <= ST_PC;
        ST_PC:   if (tick) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  tb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(st) == ST_BHI && $past(idx) == 4'd8));

  // R3
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> scl_low);

  // R8
  flag_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[0]) || $rose(status[1])) |-> $fell(busy));

  // R9
  berr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && stat_clr[3] && !flag_set[3]) |=> !status[3]);

  // R11
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !$past(scl_low) && !(st inside {ST_SB, ST_PC})
     && !($past(st) inside {ST_SB, ST_PC})) |-> $stable(sda_low));

endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  logic clk = 0, rst_n = 0;
  logic [15:0] half_period = 16'd4;
  logic ctrl_we = 0, ctrl_tb = 0, ctrl_start = 0, ctrl_stop = 0, ctrl_nak = 0, ctrl_rx = 0;
  logic [7:0] tx_data = 0;
  logic stat_we = 0;
  logic [3:0] stat_clr = 0;
  logic busy, irq, scl_low, sda_low;
  logic [7:0] rx_data;
  logic [3:0] status;

  logic s_low = 0;
  wire scl_bus = !scl_low;
  wire sda_bus = !(sda_low || s_low);

  int checks = 0, fails = 0, cyc = 0;

  i2c_byte_master dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .ctrl_we(ctrl_we), .ctrl_tb(ctrl_tb), .ctrl_start(ctrl_start), .ctrl_stop(ctrl_stop),
    .ctrl_nak(ctrl_nak), .ctrl_rx(ctrl_rx), .tx_data(tx_data),
    .stat_we(stat_we), .stat_clr(stat_clr),
    .busy(busy), .rx_data(rx_data), .status(status), .irq(irq),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_low(scl_low), .sda_low(sda_low));

  always #4 clk = ~clk;

  // slave model, sampled on the falling clock edge
  logic p_scl = 1, p_sda = 1, mack = 0, last_nak = 0, s_tx = 0, s_ack = 1;
  logic [7:0] cap = 0, got = 0, s_byte = 0;
  int bitn = 0, starts = 0, stops = 0, last_rise = 0, period = 0;

  always @(negedge clk) begin
    cyc++;
    if (p_scl && scl_bus && p_sda && !sda_bus) begin starts++; bitn = 0; last_nak = 0; end
    if (p_scl && scl_bus && !p_sda && sda_bus) stops++;
    if (!p_scl && scl_bus) begin
      period = cyc - last_rise; last_rise = cyc;
      if (bitn < 8) begin
        cap = {cap[6:0], sda_bus}; bitn++;
        if (bitn == 8) got = cap;
      end else begin
        mack = sda_bus; last_nak = sda_bus; bitn = 0;
      end
    end
    if (p_scl && !scl_bus) begin
      if (s_tx && !last_nak && bitn < 8) s_low = !s_byte[7-bitn];
      else if (!s_tx && bitn == 8)       s_low = s_ack;
      else                               s_low = 0;
    end
    p_scl = scl_bus; p_sda = sda_bus;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic tb, st, sp, nk, rx, input logic [7:0] d);
    @(negedge clk);
    ctrl_we = 1; ctrl_tb = tb; ctrl_start = st; ctrl_stop = sp; ctrl_nak = nk; ctrl_rx = rx; tx_data = d;
    @(negedge clk);
    ctrl_we = 0; ctrl_tb = 0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk); stat_we = 1; stat_clr = 4'hF;
    @(negedge clk); stat_we = 0; stat_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 scl", scl_low, 0); chk("R1 sda", sda_low, 0);
    chk("R1 busy", busy, 0); chk("R1 status", status, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_tx_first();
    int s0 = starts;
    s_tx = 0; s_ack = 1;
    wr_ctrl(1, 1, 0, 0, 0, 8'hA5);
    chk("R2 busy rises", busy, 1);
    wait_done();
    chk("R4 start from idle", starts - s0, 1);
    chk("R7 byte on wire", got, 8'hA5);
    chk("R8 tx done", status, 4'b0001);
    chk("R9 irq", irq, 1);
    chk("R10 scl period", period, 8);
    repeat (60) @(negedge clk);
    chk("R3 parked low", scl_low, 1);
  endtask

  task automatic t_clear();
    clr_all();
    chk("R9 cleared", status, 0); chk("R9 irq low", irq, 0);
  endtask

  task automatic t_tx_nak();
    int s0 = starts;
    s_ack = 0;
    wr_ctrl(1, 0, 0, 0, 0, 8'h3C);
    wait_done();
    chk("R4 no start", starts - s0, 0);
    chk("R7 byte", got, 8'h3C);
    chk("R7 bus error", status, 4'b1001);
    repeat (20) @(negedge clk);
    chk("R3 still parked", scl_low, 1);
    s_ack = 1;
    clr_all();
  endtask

  task automatic t_rstart();
    int s0 = starts;
    wr_ctrl(1, 1, 0, 0, 0, 8'h81);
    wait_done();
    chk("R4 repeated start", starts - s0, 1);
    chk("R4 byte", got, 8'h81);
    clr_all();
  endtask

  task automatic t_rx(input logic [7:0] b, input logic nk, input logic sp);
    int p0 = stops;
    @(negedge clk);
    s_tx = 1; s_byte = b; s_low = !b[7];
    wr_ctrl(1, 0, sp, nk, 1, 8'h00);
    repeat (30) @(negedge clk);
    chk("R8 no flag mid-byte", status, 0);
    chk("R5 no early stop", stops - p0, 0);
    wait_done();
    chk("R8 rx data", rx_data, b);
    chk("R6 master ack bit", mack, nk);
    if (sp) begin
      while (!status[2]) @(negedge clk);
      @(negedge clk);
      chk("R5 stop seen", stops - p0, 1);
      chk("R5 flags", status, 4'b0110);
      chk("R5 scl released", scl_low, 0);
      chk("R5 sda released", sda_low, 0);
    end else begin
      chk("R8 rx full", status, 4'b0010);
    end
    s_tx = 0; s_low = 0;
    clr_all();
  endtask

  task automatic t_ignored();
    wr_ctrl(1, 1, 0, 0, 0, 8'h12);
    repeat (20) @(negedge clk);
    wr_ctrl(1, 1, 1, 0, 1, 8'hFF);
    wait_done();
    chk("R2 data kept", got, 8'h12);
    chk("R2 direction kept", status, 4'b0001);
    repeat (20) @(negedge clk);
    chk("R2 stop not taken", scl_low, 1);
    clr_all();
  endtask

  task automatic t_default_div();
    half_period = 16'd0;
    wr_ctrl(1, 0, 0, 0, 0, 8'h6B);
    wait_done();
    chk("R10 default byte", got, 8'h6B);
    chk("R10 default period", period, 1250);
    half_period = 16'd4;
    clr_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_tx_first();
    t_clear();
    t_tx_nak();
    t_rstart();
    t_rx(8'h5E, 0, 0);
    t_rx(8'hC3, 1, 1);
    t_ignored();
    t_default_div();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1200000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule